// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Sequencing

This block sends asynchronous serial frames of 8 or 9 data bits on a single output line. Software drives it through a small register port: a global serial enable, a transmitter enable, a send-break control, a ninth transmit bit and a data holding register. The block does not generate a baud rate. It moves one bit period forward on each cycle in which the external `baud_tick` input is high, and it holds each bit on `txd` from one tick until the next.

When the transmitter becomes effectively enabled, meaning both the global enable and the transmitter enable are set, the block first sends an idle preamble. The preamble is one frame length of logic 1. After that it sends whatever is in the holding register. A break is a full frame length of logic 0. A set-then-clear pulse on the break control produces exactly one break followed by one logic-1 bit. Holding the control set produces breaks back to back with no 1s between them. A break requested after enabling, but before the preamble has started, takes the place of the preamble.

Register map, on a 2-bit address:
- Address 0: bit 0 is the global enable and bit 1 selects 9-bit mode.
- Address 1: bit 0 is the transmitter enable and bit 1 is the send-break control.
- Address 2: bit 0 is the ninth transmit bit.
- Address 3: a write loads the data holding register, and a read returns the empty flag in bit 0.

All other read bits are 0.

Top module: `sertx_brk`

## Requirements
- R1: After reset `txd` is 1 and `tx_empty` is 1. Reads of addresses 0, 1 and 2 return 0, and a read of address 3 returns 1.
- R2: A write to the transmitter enable (address 1, bit 0) is ignored while the global enable (address 0, bit 0) is clear. Read-back stays 0 and the line stays high. Once the global enable is set, the same write takes effect.
- R3: When the effective enable goes from 0 to 1, one preamble of FL logic-1 bit periods is sent, where FL is 10 in 8-bit mode and 11 in 9-bit mode. A data byte queued beforehand has its start bit at the first tick after the preamble.
- R4: An 8-bit frame is a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1: 10 bit periods in all. Each bit is held from one tick to the next. A frame that is already waiting starts on the tick right after the previous stop bit.
- R5: In 9-bit mode (address 0, bit 1) the ninth bit is taken from address 2, bit 0, and sent after data bit 7, giving 11 bit periods.
- R6: `tx_empty` falls to 0 on a write to address 3. It rises to 1 at the tick on which that byte's start bit goes out. A byte written during a frame is sent directly after that frame's stop bit.
- R7: Setting and then clearing the break control (address 1, bit 1) before the next tick sends FL bit periods of 0, then exactly one bit period of 1, then the next queued frame. A pending break goes ahead of queued data.
- R8: While the break control stays set, breaks follow one another with no 1 bits between them. After it is cleared, the break in progress completes and is followed by a logic 1.
- R9: A break requested after the effective enable rises, but before the preamble starts, is sent instead of the preamble. No preamble follows it.
- R10: `txd` is 1 whenever the transmitter is disabled, the global enable is clear, or nothing is queued. Disabling in the middle of a frame abandons the frame, and the line is high before the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data for `addr` |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | High when the holding register can take a new byte |

## Verification
The bench sends every 8-bit value, and a spread of 9-bit values with both settings of the ninth bit. A shifter with an off-by-one in its bit count, or with the wrong bit order, would then misplace the stop bit or swap data bits. It sends a single break with a byte already queued. A design that dropped the trailing 1, or that added idle time or a preamble after the break, would shift the start bit that follows. It holds the break control set across three breaks, where a stray stop bit would show up as a 1. It toggles the break in the same gap as the enable, where a design that ignored the early request would send 1s before the break. The bench also disables the transmitter mid-frame to catch a design that finishes the frame anyway, and writes the transmitter enable with the global enable off to catch an unguarded write.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Register port address width and register addresses.
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;   // global enable, 9-bit mode
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;   // transmitter enable, break
    localparam logic [ADDR_W-1:0] A_EXT  = 2'd2;   // ninth transmit bit
    localparam logic [ADDR_W-1:0] A_DATA = 2'd3;   // holding register / empty flag

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_BRK,
        ST_MARK
    } tx_state_e;

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              load_ack,
    output logic              glob_en,
    output logic              nine_mode,
    output logic              tx_en,
    output logic              brk_req,
    output logic              bit9,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty,
    output logic              brk_set
);

    typedef struct packed {
        logic              glob;
        logic              nine;
        logic              ten;
        logic              brk;
        logic              t8;
        logic [DATA_W-1:0] hold;
        logic              empty;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_ack) begin
            r_d.empty = 1'b1;
        end
        if (wr_en) begin
            case (addr)
                A_MODE: begin
                    r_d.glob = wdata[0];
                    r_d.nine = wdata[1];
                end
                A_CTRL: begin
                    if (r_q.glob) begin
                        r_d.ten = wdata[0];
                    end
                    r_d.brk = wdata[1];
                end
                A_EXT: begin
                    r_d.t8 = wdata[0];
                end
                default: begin
                    r_d.hold  = wdata;
                    r_d.empty = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // A break request counts only when the transmitter is, or is just
    // becoming, effectively enabled.
    always_comb begin
        brk_set = wr_en && (addr == A_CTRL) && wdata[1] && r_q.glob
                  && (r_q.ten || wdata[0]);
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: begin
                rdata[0] = r_q.glob;
                rdata[1] = r_q.nine;
            end
            A_CTRL: begin
                rdata[0] = r_q.ten;
                rdata[1] = r_q.brk;
            end
            A_EXT: begin
                rdata[0] = r_q.t8;
            end
            default: begin
                rdata[0] = r_q.empty;
            end
        endcase
    end

    assign glob_en    = r_q.glob;
    assign nine_mode  = r_q.nine;
    assign tx_en      = r_q.ten;
    assign brk_req    = r_q.brk;
    assign bit9       = r_q.t8;
    assign hold_data  = r_q.hold;
    assign hold_empty = r_q.empty;

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
    parameter int DATA_W = 8,
    localparam int SH_W  = DATA_W + 2,
    localparam int CNT_W = $clog2(DATA_W + 4)
) (
    input  logic              nine_mode,
    input  logic              bit9,
    input  logic [DATA_W-1:0] data,
    output logic [SH_W-1:0]   shift_vec,
    output logic [CNT_W-1:0]  frame_len
);

    // The shifter is loaded with data, then the slot for the ninth bit,
    // then the stop bit. In 8-bit mode the ninth slot holds 1 and becomes
    // the stop bit, because the frame is one period shorter.
    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        assign shift_vec[i] = data[i];
    end

    assign shift_vec[DATA_W]     = nine_mode ? bit9 : 1'b1;
    assign shift_vec[DATA_W + 1] = 1'b1;

    assign frame_len = nine_mode ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SH_W  = DATA_W + 2,
    localparam int CNT_W = $clog2(DATA_W + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             active,
    input  logic             brk_req,
    input  logic             brk_set,
    input  logic             hold_empty,
    input  logic [SH_W-1:0]  shift_vec,
    input  logic [CNT_W-1:0] frame_len,
    output logic             txd,
    output logic             load_ack,
    output logic             in_brk
);

    typedef struct packed {
        tx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
        logic             txd;
        logic             brk_pend;
        logic             pre_pend;
        logic             act_prev;
    } seq_t;

    seq_t s_d, s_q;

    logic rise, pre_want, brk_pend_w, want_brk, frame_done;

    always_comb begin
        s_d      = s_q;
        load_ack = 1'b0;

        rise       = active && !s_q.act_prev;
        pre_want   = s_q.pre_pend || rise;
        brk_pend_w = s_q.brk_pend || brk_set;
        want_brk   = brk_req || brk_pend_w;
        frame_done = (s_q.state == ST_IDLE) || (s_q.cnt == '0);

        s_d.act_prev = active;
        s_d.pre_pend = pre_want;
        s_d.brk_pend = brk_pend_w;

        if (!active) begin
            s_d.state    = ST_IDLE;
            s_d.txd      = 1'b1;
            s_d.cnt      = '0;
            s_d.pre_pend = 1'b0;
            s_d.brk_pend = brk_set;
        end else if (baud_tick) begin
            if (!frame_done) begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                case (s_q.state)
                    ST_DATA: begin
                        s_d.txd = s_q.sh[0];
                        s_d.sh  = {1'b1, s_q.sh[SH_W-1:1]};
                    end
                    ST_BRK:  s_d.txd = 1'b0;
                    default: s_d.txd = 1'b1;
                endcase
            end else if (s_q.state == ST_BRK && !want_brk) begin
                // One mark period after the final break.
                s_d.state = ST_MARK;
                s_d.txd   = 1'b1;
                s_d.cnt   = '0;
            end else if (want_brk) begin
                s_d.state    = ST_BRK;
                s_d.txd      = 1'b0;
                s_d.cnt      = frame_len - CNT_W'(1);
                s_d.brk_pend = 1'b0;
                s_d.pre_pend = 1'b0;
            end else if (pre_want) begin
                s_d.state    = ST_PRE;
                s_d.txd      = 1'b1;
                s_d.cnt      = frame_len - CNT_W'(1);
                s_d.pre_pend = 1'b0;
            end else if (!hold_empty) begin
                s_d.state = ST_DATA;
                s_d.txd   = 1'b0;
                s_d.sh    = shift_vec;
                s_d.cnt   = frame_len - CNT_W'(1);
                load_ack  = 1'b1;
            end else begin
                s_d.state = ST_IDLE;
                s_d.txd   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.txd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd    = s_q.txd;
    assign in_brk = (s_q.state == ST_BRK);

endmodule

// File: rtl/sertx_brk.sv
module sertx_brk
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SH_W  = DATA_W + 2,
    localparam int CNT_W = $clog2(DATA_W + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              baud_tick,
    output logic              txd,
    output logic              tx_empty
);

    logic              glob_w, nine_w, ten_w, brk_w, bit9_w, empty_w;
    logic              brk_set_w, load_ack_w, act_w, in_brk_w;
    logic [DATA_W-1:0] hold_w;
    logic [SH_W-1:0]   shift_w;
    logic [CNT_W-1:0]  flen_w;

    sertx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .load_ack   (load_ack_w),
        .glob_en    (glob_w),
        .nine_mode  (nine_w),
        .tx_en      (ten_w),
        .brk_req    (brk_w),
        .bit9       (bit9_w),
        .hold_data  (hold_w),
        .hold_empty (empty_w),
        .brk_set    (brk_set_w)
    );

    sertx_framer #(.DATA_W(DATA_W)) u_framer (
        .nine_mode (nine_w),
        .bit9      (bit9_w),
        .data      (hold_w),
        .shift_vec (shift_w),
        .frame_len (flen_w)
    );

    assign act_w = glob_w && ten_w;

    sertx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .active     (act_w),
        .brk_req    (brk_w),
        .brk_set    (brk_set_w),
        .hold_empty (empty_w),
        .shift_vec  (shift_w),
        .frame_len  (flen_w),
        .txd        (txd),
        .load_ack   (load_ack_w),
        .in_brk     (in_brk_w)
    );

    assign tx_empty = empty_w;

endmodule

// File: rtl/sertx_brk_chk.sv
module sertx_brk_chk
    import sertx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              glob_en,
    input logic              tx_en,
    input logic              active,
    input logic              brk_req,
    input logic              in_brk,
    input logic              txd,
    input logic              tx_empty
);

    // R2: with the global enable clear, the transmitter enable holds its value.
    a_r2_ten_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && !glob_en) |=> (tx_en == $past(tx_en)));

    // R10: one cycle after the transmitter is inactive, the line is high.
    a_r10_line_high_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> txd);

    // R8: a held break request keeps the line low from break to break.
    a_r8_break_run_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_brk && brk_req && active) |=> !txd);

    // R6: a data write always leaves the holding register full.
    a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA) |=> !tx_empty);

    // R6: the empty flag falls only after a data write.
    a_r6_empty_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en && addr == A_DATA));

endmodule

bind sertx_brk sertx_brk_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .glob_en  (glob_w),
    .tx_en    (ten_w),
    .active   (act_w),
    .brk_req  (brk_w),
    .in_brk   (in_brk_w),
    .txd      (txd),
    .tx_empty (tx_empty)
);

// File: tb/sertx_brk_tb.sv
module sertx_brk_tb;
    import sertx_pkg::*;

    localparam int DW       = 8;
    localparam int TICK_DIV = 16;
    localparam int FL8      = DW + 2;
    localparam int FL9      = DW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic          baud_tick = 1'b0;
    wire  [DW-1:0] rdata;
    wire           txd;
    wire           tx_empty;

    int n_chk = 0;
    int n_bad = 0;

    sertx_brk #(.DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .baud_tick (baud_tick),
        .txd       (txd),
        .tx_empty  (tx_empty)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            for (int i = 0; i < TICK_DIV; i++) begin
                @(negedge clk);
                baud_tick = (i == 0);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..R10 run) actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic next_bit(output logic b);
        @(posedge clk);
        while (baud_tick !== 1'b1) @(posedge clk);
        @(negedge clk);
        b = txd;
    endtask

    task automatic get_bits(input int n, output logic [63:0] v);
        logic b;
        v = '0;
        for (int i = 0; i < n; i++) begin
            next_bit(b);
            v[i] = b;
        end
    endtask

    function automatic logic [63:0] ones(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [63:0] frame8(input logic [7:0] d);
        return 64'({1'b1, d, 1'b0});
    endfunction

    function automatic logic [63:0] frame9(input logic [7:0] d, input logic t8);
        return 64'({1'b1, t8, d, 1'b0});
    endfunction

    logic [63:0]   v;
    logic [DW-1:0] r;
    logic          b;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "txd after reset", 64'(txd), 64'd1);
        chk("R1", "tx_empty after reset", 64'(tx_empty), 64'd1);
        rd(A_MODE, r); chk("R1", "mode read", 64'(r), 64'd0);
        rd(A_CTRL, r); chk("R1", "ctrl read", 64'(r), 64'd0);
        rd(A_EXT,  r); chk("R1", "ext read",  64'(r), 64'd0);
        rd(A_DATA, r); chk("R1", "empty read", 64'(r), 64'd1);

        // R2: enable write blocked while global enable is off
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, r); chk("R2", "ten blocked", 64'(r), 64'd0);
        get_bits(12, v); chk("R10", "line high when off", v, ones(12));
        wr(A_MODE, 8'h01);
        rd(A_CTRL, r); chk("R2", "ten still clear after glob on", 64'(r), 64'd0);
        get_bits(12, v); chk("R10", "line high, glob only", v, ones(12));

        // R3: preamble before queued data
        next_bit(b);
        wr(A_DATA, 8'h5A);
        chk("R6", "empty low after write", 64'(tx_empty), 64'd0);
        wr(A_CTRL, 8'h01);
        get_bits(2 * FL8 + 2, v);
        chk("R3", "preamble then frame", v,
            ones(FL8) | (frame8(8'h5A) << FL8) | (ones(2) << (2 * FL8)));
        chk("R6", "empty high after start", 64'(tx_empty), 64'd1);
        rd(A_CTRL, r); chk("R2", "ten accepted with glob on", 64'(r), 64'd1);

        // R4: every 8-bit value
        for (int d = 0; d < 256; d++) begin
            wr(A_DATA, 8'(d));
            get_bits(FL8, v);
            chk("R4", $sformatf("frame of %02h", d), v, frame8(8'(d)));
        end
        chk("R6", "empty after sweep", 64'(tx_empty), 64'd1);

        // R5: 9-bit mode, both ninth-bit values
        wr(A_MODE, 8'h03);
        for (int i = 0; i < 32; i++) begin
            wr(A_EXT, 8'(i & 1));
            wr(A_DATA, 8'((i * 37 + 1) & 8'hFF));
            get_bits(FL9, v);
            chk("R5", $sformatf("9-bit frame %0d", i), v,
                frame9(8'((i * 37 + 1) & 8'hFF), 1'(i & 1)));
        end

        // R6: byte written mid-frame goes right after the stop bit
        wr(A_EXT, 8'h01);
        wr(A_DATA, 8'hC3);
        get_bits(2, v);
        chk("R6", "empty after load", 64'(tx_empty), 64'd1);
        wr(A_DATA, 8'h3C);
        chk("R6", "empty low after mid-frame write", 64'(tx_empty), 64'd0);
        get_bits(2 * FL9 - 2, v);
        chk("R6", "back-to-back frames", v,
            (frame9(8'hC3, 1'b1) >> 2) | (frame9(8'h3C, 1'b1) << (FL9 - 2)));
        wr(A_MODE, 8'h01);
        get_bits(2, v); chk("R10", "idle high", v, ones(2));

        // R7: single break, then exactly one 1, then the queued byte
        wr(A_DATA, 8'hFF);
        wr(A_CTRL, 8'h03);
        wr(A_CTRL, 8'h01);
        get_bits(2 * FL8 + 2, v);
        chk("R7", "single break", v,
            (64'd1 << FL8) | (frame8(8'hFF) << (FL8 + 1)) | (64'd1 << (2 * FL8 + 1)));
        rd(A_CTRL, r); chk("R7", "break bit clear", 64'(r), 64'd1);

        // R8: continuous breaks
        wr(A_CTRL, 8'h03);
        get_bits(3 * FL8, v);
        chk("R8", "three breaks no ones", v, 64'd0);
        wr(A_CTRL, 8'h01);
        get_bits(3, v);
        chk("R8", "mark after break release", v, ones(3));

        // R9: early break replaces preamble
        wr(A_CTRL, 8'h00);
        get_bits(3, v); chk("R10", "disabled high", v, ones(3));
        wr(A_DATA, 8'h00);
        wr(A_CTRL, 8'h03);
        wr(A_CTRL, 8'h01);
        get_bits(2 * FL8 + 2, v);
        chk("R9", "break instead of preamble", v,
            (64'd1 << FL8) | (frame8(8'h00) << (FL8 + 1)) | (64'd1 << (2 * FL8 + 1)));

        // R10: disable mid-frame
        wr(A_DATA, 8'h00);
        get_bits(3, v); chk("R4", "frame head", v, 64'd0);
        wr(A_CTRL, 8'h00);
        get_bits(6, v); chk("R10", "abandoned frame high", v, ones(6));
        chk("R10", "empty after abandon", 64'(tx_empty), 64'd1);

        // R10: global enable off mid-frame
        wr(A_CTRL, 8'h01);
        get_bits(FL8, v); chk("R3", "preamble on re-enable", v, ones(FL8));
        wr(A_DATA, 8'h00);
        get_bits(2, v); chk("R4", "start of frame", v, 64'd0);
        wr(A_MODE, 8'h00);
        get_bits(4, v); chk("R10", "glob off high", v, ones(4));

        summary();
        $finish;
    end

endmodule